// File: doc/BRIEF.md
# Multi-Depth Pixel Colorizer

This stage sits between a scanout FIFO and the video encoder of a framebuffer display path. It takes wide memory words from a first-word-fall-through FIFO and splits each word into pixels at one of six selectable color depths. It turns every pixel into 24-bit RGB. Depths of 8 bits or fewer index a writable 256-entry palette. 16-bit pixels have their channels widened, and 32-bit pixels are used as they stand. Inside the content window the framebuffer pixel is shown. Outside the window, but while the line is active, a programmable background color is shown instead.

A hardware cursor is laid over the result. The timing generator supplies a 2-bit cursor code for every pixel. Two of the codes pick one of two colors from a small private cursor palette, one inverts the color underneath, and one leaves it untouched. All sync and enable signals pass through the same number of register stages as the pixel data, so the encoder receives them exactly aligned.

The FIFO is read with a pop strobe. A pop is issued only in the cycle that consumes the last pixel of the current word. The palette can be rewritten at any time through a simple write port.

Top module: `pxc_stage`

## Requirements
- R1: While reset is held and right after it, `out_rgb`, `out_hs`, `out_vs` and `out_de` are 0 and `fifo_pop` is 0.
- R2: `out_hs`, `out_vs` and `out_de` equal `tg_hs`, `tg_vs` and `tg_de` from exactly 3 clock cycles earlier. The colour for a pixel presented on the inputs appears on `out_rgb` in the same cycle as its delayed sync bits.
- R3: In a cycle where the delayed `out_de` is 0, `out_rgb` is 0.
- R4: `depth_sel` codes 0,1,2,3,4,5 select 1,2,4,8,16,32 bits per pixel. The first pixel of a word is its most significant bits. A pixel is consumed only in a cycle where both `tg_de` and `tg_win` are 1.
- R5: At 1, 2, 4 and 8 bpp the pixel value, zero-extended to 8 bits, addresses the palette. A palette entry holds red in bits 23:16, green in 15:8 and blue in 7:0, which is also the `out_rgb` layout.
- R6: At 16 bpp bit 15 is ignored, and red, green and blue are bits 14:10, 9:5 and 4:0. Each 5-bit field c becomes the 8-bit channel {c, c[4:2]}.
- R7: At 32 bpp bits 23:0 are output as RGB and bits 31:24 are ignored.
- R8: `fifo_pop` is 1 only in the cycle that consumes the last pixel of a word, 128/bpp pixels after the previous pop. It is never 1 in two consecutive cycles.
- R9: When `tg_de` is 1 and `tg_win` is 0, the output is `bg_rgb` (subject to R10) and no pixel is consumed.
- R10: `tg_cur` code 0 is transparent, code 1 shows cursor color 1, code 2 shows cursor color 2, and code 3 shows the bitwise inverse of the underlying color (pixel or background). A cursor write with `cpal_sel`=0 loads color 1 and one with `cpal_sel`=1 loads color 2.
- R11: A palette write is accepted in any cycle, including during active display. It is seen by every pixel presented on the inputs in the same cycle as the write or later, and it leaves the other entries being displayed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 3 | Color depth code (0..5 = 1..32 bpp) |
| fifo_data | input | 128 | Head word of the scanout FIFO |
| fifo_pop | output | 1 | Removes the head word from the FIFO |
| tg_de | input | 1 | Active-video enable from the timing generator |
| tg_hs | input | 1 | Horizontal sync from the timing generator |
| tg_vs | input | 1 | Vertical sync from the timing generator |
| tg_win | input | 1 | Inside the content window |
| tg_cur | input | 2 | Cursor code for this pixel |
| bg_rgb | input | 24 | Background color outside the window |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 8 | Palette entry to write |
| pal_wdata | input | 24 | Palette color to write |
| cpal_we | input | 1 | Cursor palette write strobe |
| cpal_sel | input | 1 | Cursor color select (0: color 1, 1: color 2) |
| cpal_wdata | input | 24 | Cursor color to write |
| out_rgb | output | 24 | Pixel color to the encoder |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
The assertions watch, on every cycle, the 3-cycle alignment of the sync and enable outputs with their inputs, black output during blanking, background fill outside the window when no cursor is present, and the fact that pops are never back to back. The correctness of the colors themselves can be shown only by the bench's scenarios. These cover the unpack order and pixel count per word at each depth, the palette, channel widening and pass-through conversions, the four cursor codes over both framebuffer and background, and palette rewrites during display. The exact cycle of each pop is also left to the bench, which checks the FIFO read position at word boundaries.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

   typedef enum logic [2:0] {
      DEPTH_1  = 3'd0,
      DEPTH_2  = 3'd1,
      DEPTH_4  = 3'd2,
      DEPTH_8  = 3'd3,
      DEPTH_16 = 3'd4,
      DEPTH_32 = 3'd5
   } depth_e;

   typedef enum logic [1:0] {
      CUR_CLEAR = 2'd0,
      CUR_COL1  = 2'd1,
      CUR_COL2  = 2'd2,
      CUR_INV   = 2'd3
   } cur_e;

   // log2 of bits per pixel; reserved codes behave as 32 bpp
   function automatic logic [2:0] depth_log2(input logic [2:0] d);
      return (d > 3'd5) ? 3'd5 : d;
   endfunction

endpackage

// File: rtl/pxc_unpack.sv
module pxc_unpack
   import pxc_pkg::*;
#(
   parameter int WORD_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        depth,
   input  logic              take,
   input  logic [WORD_W-1:0] word,
   output logic              pop,
   output logic [31:0]       pix
);

   localparam int CNT_W = $clog2(WORD_W);

   if (WORD_W < 64 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("pxc_unpack: WORD_W must be a power of two and at least 64");
   end

   logic [CNT_W-1:0]   slot;
   logic [CNT_W-1:0]   last_slot;
   logic [CNT_W-1:0]   bpp_v;
   logic [CNT_W-1:0]   shamt;
   logic [2:0]         lg;
   logic [WORD_W+31:0] padded;
   logic [31:0]        top32;

   always_comb begin
      lg        = depth_log2(depth);
      bpp_v     = CNT_W'(1) << lg;
      last_slot = CNT_W'((WORD_W >> lg) - 1);
      shamt     = slot * bpp_v;
      padded    = {word, 32'd0};
      top32     = padded[(WORD_W + 31) - int'(shamt) -: 32];
      case (lg)
         3'd0:    pix = {31'd0, top32[31]};
         3'd1:    pix = {30'd0, top32[31:30]};
         3'd2:    pix = {28'd0, top32[31:28]};
         3'd3:    pix = {24'd0, top32[31:24]};
         3'd4:    pix = {16'd0, top32[31:16]};
         default: pix = top32;
      endcase
   end

   assign pop = take && (slot == last_slot);

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot <= '0;
      else if (take)
         slot <= pop ? '0 : slot + 1'b1;
   end

   // R8
   pop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !pop);

endmodule

// File: rtl/pxc_delay.sv
module pxc_delay #(
   parameter int W = 8,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (N < 1) begin : g_bad_depth
      $error("pxc_delay: N must be at least 1");
   end

   logic [W-1:0] stg [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[N-1];

endmodule

// File: rtl/pxc_palette.sv
module pxc_palette #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int ENTRIES = 1 << IDX_W;

   if (IDX_W > 10) begin : g_bad_idx
      $error("pxc_palette: IDX_W too large for a register palette");
   end

   logic [DATA_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/pxc_colorize.sv
module pxc_colorize
   import pxc_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        depth,
   input  logic [31:0]       raw,
   input  logic [3*CH_W-1:0] pal_rgb,
   input  logic              de,
   input  logic              win,
   input  logic              hs,
   input  logic              vs,
   input  logic [1:0]        cur,
   input  logic [3*CH_W-1:0] bg_rgb,
   input  logic              cpal_we,
   input  logic              cpal_sel,
   input  logic [3*CH_W-1:0] cpal_wdata,
   output logic [3*CH_W-1:0] out_rgb,
   output logic              out_hs,
   output logic              out_vs,
   output logic              out_de
);

   localparam int RGB_W = 3 * CH_W;

   if (CH_W < 5 || CH_W > 8) begin : g_bad_ch
      $error("pxc_colorize: CH_W must lie between 5 and 8");
   end

   function automatic logic [CH_W-1:0] widen5(input logic [4:0] c);
      logic [CH_W-1:0] r;
      for (int i = 0; i < CH_W; i++) r[CH_W-1-i] = c[4 - (i % 5)];
      return r;
   endfunction

   // Cursor palette: one register per color
   for (genvar e = 0; e < 2; e++) begin : g_cpal
      logic [RGB_W-1:0] ent;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent <= '0;
         else if (cpal_we && cpal_sel == 1'(e))
            ent <= cpal_wdata;
      end
   end

   logic [RGB_W-1:0] exp16, pass32, fb, under, mix;
   logic             unused_raw;

   for (genvar c = 0; c < 3; c++) begin : g_chan
      assign exp16[CH_W*c +: CH_W]  = widen5(raw[5*c +: 5]);
      assign pass32[CH_W*c +: CH_W] = raw[8*c+7 -: CH_W];
   end

   assign unused_raw = ^{raw[31:24], raw[15]};

   always_comb begin
      case (depth_e'(depth))
         DEPTH_1, DEPTH_2, DEPTH_4, DEPTH_8: fb = pal_rgb;
         DEPTH_16:                          fb = exp16;
         default:                           fb = pass32;
      endcase
      under = win ? fb : bg_rgb;
      case (cur_e'(cur))
         CUR_CLEAR: mix = under;
         CUR_COL1:  mix = g_cpal[0].ent;
         CUR_COL2:  mix = g_cpal[1].ent;
         default:   mix = ~under;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_rgb <= '0;
         out_hs  <= 1'b0;
         out_vs  <= 1'b0;
         out_de  <= 1'b0;
      end else begin
         out_rgb <= de ? mix : '0;
         out_hs  <= hs;
         out_vs  <= vs;
         out_de  <= de;
      end
   end

   // R3
   blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_de |-> (out_rgb == '0));

endmodule

// File: rtl/pxc_stage.sv
module pxc_stage
   import pxc_pkg::*;
#(
   parameter int WORD_W = 128,
   parameter int CH_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        depth_sel,
   input  logic [WORD_W-1:0] fifo_data,
   output logic              fifo_pop,
   input  logic              tg_de,
   input  logic              tg_hs,
   input  logic              tg_vs,
   input  logic              tg_win,
   input  logic [1:0]        tg_cur,
   input  logic [3*CH_W-1:0] bg_rgb,
   input  logic              pal_we,
   input  logic [7:0]        pal_waddr,
   input  logic [3*CH_W-1:0] pal_wdata,
   input  logic              cpal_we,
   input  logic              cpal_sel,
   input  logic [3*CH_W-1:0] cpal_wdata,
   output logic [3*CH_W-1:0] out_rgb,
   output logic              out_hs,
   output logic              out_vs,
   output logic              out_de
);

   localparam int RGB_W = 3 * CH_W;
   localparam int IDX_W = 8;
   localparam int SB_W  = 32 + 6;

   logic             take;
   logic [31:0]      pix_raw;
   logic [SB_W-1:0]  s0_bus, s1_bus, s2_bus;
   logic [RGB_W-1:0] pal_rgb;

   assign take = tg_de && tg_win;

   pxc_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk   (clk),
      .rst_n (rst_n),
      .depth (depth_sel),
      .take  (take),
      .word  (fifo_data),
      .pop   (fifo_pop),
      .pix   (pix_raw)
   );

   assign s0_bus = {pix_raw, tg_de, tg_win, tg_hs, tg_vs, tg_cur};

   pxc_delay #(.W(SB_W), .N(1)) u_stage1 (
      .clk (clk), .rst_n (rst_n), .d (s0_bus), .q (s1_bus)
   );

   pxc_delay #(.W(SB_W), .N(1)) u_stage2 (
      .clk (clk), .rst_n (rst_n), .d (s1_bus), .q (s2_bus)
   );

   pxc_palette #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_palette (
      .clk   (clk),
      .we    (pal_we),
      .waddr (pal_waddr),
      .wdata (pal_wdata),
      .raddr (s1_bus[6 +: IDX_W]),
      .rdata (pal_rgb)
   );

   pxc_colorize #(.CH_W(CH_W)) u_colorize (
      .clk        (clk),
      .rst_n      (rst_n),
      .depth      (depth_sel),
      .raw        (s2_bus[SB_W-1 -: 32]),
      .pal_rgb    (pal_rgb),
      .de         (s2_bus[5]),
      .win        (s2_bus[4]),
      .hs         (s2_bus[3]),
      .vs         (s2_bus[2]),
      .cur        (s2_bus[1:0]),
      .bg_rgb     (bg_rgb),
      .cpal_we    (cpal_we),
      .cpal_sel   (cpal_sel),
      .cpal_wdata (cpal_wdata),
      .out_rgb    (out_rgb),
      .out_hs     (out_hs),
      .out_vs     (out_vs),
      .out_de     (out_de)
   );

   // Cycles since reset, saturating, so that $past never reaches into reset
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n)
         warm <= '0;
      else if (warm != 2'd3)
         warm <= warm + 2'd1;
   end

   // R2
   sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (out_hs == $past(tg_hs, 3) &&
                          out_vs == $past(tg_vs, 3) &&
                          out_de == $past(tg_de, 3)));

   // R9
   bg_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm == 2'd3) && $past(tg_de && !tg_win && tg_cur == 2'd0, 3))
         |-> (out_rgb == $past(bg_rgb, 1)));

endmodule

// File: tb/pxc_stage_tb.sv
module pxc_stage_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   depth_sel = 3'd0;
   logic [127:0] fifo_data;
   logic         fifo_pop;
   logic         tg_de = 1'b0, tg_hs = 1'b0, tg_vs = 1'b0, tg_win = 1'b0;
   logic [1:0]   tg_cur = 2'd0;
   logic [23:0]  bg_rgb = 24'h203040;
   logic         pal_we = 1'b0;
   logic [7:0]   pal_waddr = 8'd0;
   logic [23:0]  pal_wdata = 24'd0;
   logic         cpal_we = 1'b0, cpal_sel = 1'b0;
   logic [23:0]  cpal_wdata = 24'd0;
   logic [23:0]  out_rgb;
   logic         out_hs, out_vs, out_de;

   always #4 clk = ~clk;

   pxc_stage u_dut (
      .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .fifo_data(fifo_data),
      .fifo_pop(fifo_pop), .tg_de(tg_de), .tg_hs(tg_hs), .tg_vs(tg_vs),
      .tg_win(tg_win), .tg_cur(tg_cur), .bg_rgb(bg_rgb), .pal_we(pal_we),
      .pal_waddr(pal_waddr), .pal_wdata(pal_wdata), .cpal_we(cpal_we),
      .cpal_sel(cpal_sel), .cpal_wdata(cpal_wdata), .out_rgb(out_rgb),
      .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
   );

   // FIFO model (first word falls through)
   logic [127:0] words [32];
   int           wn = 0;
   int           rp = 0;
   assign fifo_data = words[rp[4:0]];
   always @(posedge clk) if (fifo_pop) rp <= rp + 1;

   // Reference state
   logic [23:0] ref_pal [256];
   logic [23:0] ref_c1 = 24'd0, ref_c2 = 24'd0;
   int          ref_rp = 0, ref_slot = 0;

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Pending writes applied by the driver
   logic        p_we = 1'b0;  logic [7:0] p_addr = 8'd0; logic [23:0] p_data = 24'd0;
   logic        c_we = 1'b0;  logic c_sel = 1'b0;        logic [23:0] c_data = 24'd0;

   typedef struct {
      logic [23:0] rgb;
      logic [2:0]  sync;
      int          due;
      string       tag;
   } exp_t;
   exp_t sb [$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic next_pix(output logic [23:0] col);
      int           bpp = 1 << depth_sel;
      int           ppw = 128 / bpp;
      logic [31:0]  v = 32'd0;
      logic [127:0] w = words[ref_rp[4:0]];
      for (int b = 0; b < bpp; b++) v[bpp-1-b] = w[127 - ref_slot*bpp - b];
      if (depth_sel <= 3'd3)
         col = ref_pal[v[7:0]];
      else if (depth_sel == 3'd4)
         col = {v[14:10], v[14:12], v[9:5], v[9:7], v[4:0], v[4:2]};
      else
         col = v[23:0];
      ref_slot++;
      if (ref_slot == ppw) begin
         ref_slot = 0;
         ref_rp++;
      end
   endtask

   // Driver: applies one cycle of stimulus and queues its expected result
   task automatic drive(input logic de, input logic win, input logic hs,
                        input logic vs, input logic [1:0] cur);
      exp_t        e;
      logic [23:0] base, col;
      @(posedge clk); #1;
      pal_we = p_we; pal_waddr = p_addr; pal_wdata = p_data;
      if (p_we) ref_pal[p_addr] = p_data;
      p_we = 1'b0;
      cpal_we = c_we; cpal_sel = c_sel; cpal_wdata = c_data;
      if (c_we) begin
         if (c_sel) ref_c2 = c_data; else ref_c1 = c_data;
      end
      c_we = 1'b0;
      tg_de = de; tg_win = win; tg_hs = hs; tg_vs = vs; tg_cur = cur;
      base = bg_rgb;
      if (de && win) next_pix(base);
      case (cur)
         2'd1:    col = ref_c1;
         2'd2:    col = ref_c2;
         2'd3:    col = ~base;
         default: col = base;
      endcase
      e.rgb  = de ? col : 24'd0;
      e.sync = {de, hs, vs};
      e.due  = cyc + 3;
      if (!de)              e.tag = "R3 blank";
      else if (cur != 2'd0) e.tag = "R10 cursor";
      else if (!win)        e.tag = "R9 background";
      else if (depth_sel <= 3'd3) e.tag = "R5 R4 indexed";
      else if (depth_sel == 3'd4) e.tag = "R6 R4 16bpp";
      else                  e.tag = "R7 R4 32bpp";
      sb.push_back(e);
   endtask

   // Monitor: pops the scoreboard as results emerge
   always @(negedge clk) begin : mon
      exp_t e;
      if (sb.size() > 0 && sb[0].due == cyc) begin
         e = sb.pop_front();
         check(e.tag, {8'd0, out_rgb}, {8'd0, e.rgb});
         check("R2 sync", {29'd0, out_de, out_hs, out_vs}, {29'd0, e.sync});
      end
   end

   task automatic blanks(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, i[0], 1'b0, 2'd0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      int start;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rgb", {8'd0, out_rgb}, 32'd0);
      check("R1 sync", {29'd0, out_de, out_hs, out_vs}, 32'd0);
      check("R1 pop", {31'd0, fifo_pop}, 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {7'd0, fifo_pop, out_rgb}, 32'd0);

      // Palette load during blanking, with sync patterns (R3, R2)
      for (int i = 0; i < 256; i++) begin
         p_we = 1'b1; p_addr = 8'(i);
         p_data = {8'(i), ~8'(i), 8'(i) ^ 8'h5A};
         drive(1'b0, 1'b0, i[3], i[5], 2'd0);
      end
      c_we = 1'b1; c_sel = 1'b0; c_data = 24'hF0E0D0; drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
      c_we = 1'b1; c_sel = 1'b1; c_data = 24'h0A0B0C; drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
      blanks(4);

      // Every depth: two words, pop timing (R4..R8)
      for (int d = 0; d < 6; d++) begin
         int ppw;
         depth_sel = 3'(d);
         ppw = 128 / (1 << d);
         start = wn;
         for (int k = 0; k < 2; k++) begin
            words[wn[4:0]] = {$urandom, $urandom, $urandom, $urandom};
            wn++;
         end
         for (int i = 0; i < ppw - 1; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
         #1 check("R8 no early pop", {31'd0, fifo_pop}, 32'd0);
         drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
         check("R8 word kept", 32'(rp), 32'(start));
         drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
         #1 check("R8 pop on last pixel", {31'd0, fifo_pop}, 32'd1);
         for (int i = 0; i < ppw; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
         blanks(4);
         check("R8 words consumed", 32'(rp), 32'(start + 2));
      end

      // Window gaps at 8 bpp (R9)
      depth_sel = 3'd3;
      start = wn;
      for (int k = 0; k < 2; k++) begin
         words[wn[4:0]] = {$urandom, $urandom, $urandom, $urandom};
         wn++;
      end
      for (int i = 0; ref_rp != wn; i++)
         drive(1'b1, (i % 3) != 0, i[2], 1'b0, 2'd0);
      blanks(4);
      check("R9 no consume outside window", 32'(rp), 32'(start + 2));

      // Cursor over pixels and background at 16 bpp (R10)
      depth_sel = 3'd4;
      for (int k = 0; k < 3; k++) begin
         words[wn[4:0]] = {$urandom, $urandom, $urandom, $urandom};
         wn++;
      end
      for (int i = 0; ref_rp != wn; i++)
         drive(1'b1, (i % 4) != 3, 1'b0, i[3], 2'((i / 2) % 4));
      blanks(4);

      // Palette rewrite during display (R11)
      depth_sel = 3'd3;
      words[wn[4:0]] = {16{8'h11}}; wn++;
      words[wn[4:0]] = {16{8'h22}}; wn++;
      for (int i = 0; i < 16; i++) begin
         p_we = 1'b1; p_addr = 8'h22; p_data = 24'hA00000 + 24'(i);
         drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
      end
      for (int i = 0; i < 16; i++) begin
         p_we = 1'b1; p_addr = 8'h11; p_data = 24'h00C000 + 24'(i);
         drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
      end
      blanks(6);
      check("R11 words consumed", 32'(rp), 32'(wn));

      summary();
      $finish;
   end

endmodule